// File: doc/BRIEF.md
# Transmit Clock Activity Mode Controller

This block watches the transmit clock of each of eight channels, together with a shared master clock, and decides from their activity what each transmitter and the common receive path should be doing. All nine clocks enter as plain data. A fast system clock oversamples them through two-flop synchronizers and finds their edges. A clock counts as running when it shows an edge within a short window of system-clock cycles. Otherwise it is static.

For each channel the block counts how long the transmit clock has stayed at one level. The count is taken in ticks of a timing reference. That reference is the master clock while it runs. When the master clock is static, the transmit clock of channel 1 takes its place. A transmit clock stuck high long enough selects transmit-all-ones (TAOS). A transmit clock stuck low long enough selects power-down. When neither reference runs, every channel is forced to high-impedance. The receive path state depends only on the master clock.

The outputs are control levels, not a data stream, so they carry no valid/ready handshake. Each output is a plain level that downstream logic samples whenever it needs it. Generating the all-ones pattern and driving the line are not part of this block.

Top module: `txclk_mode_ctrl`

## Requirements
- R1: After reset, every channel state is 11 (high-Z, no reference), `rx_state` is 10 (powered down) and every `taos_src_mclk` bit is 0, until the clocks show activity.
- R2: A clock is running when a synchronized edge of it was seen within the last 8 system-clock cycles. With the master clock and a channel's transmit clock both running, that channel's 2-bit state (bits 2i+1:2i of `chan_state`) is 00 (normal).
- R3: A transmit clock held high for more than 16 reference ticks gives channel state 01 (TAOS). After 16 or fewer ticks the state stays 00.
- R4: A transmit clock held low for 64 reference ticks gives channel state 10 (power-down, driver outputs high-Z). Fewer ticks leave the state at 00.
- R5: While the master clock is static, the reference tick is the rising edge of channel 1's transmit clock, and the thresholds of R3 and R4 apply unchanged. While the master clock runs, the tick is its rising edge.
- R6: Each `taos_src_mclk` bit is 1 while the master clock runs, meaning the all-ones generator is timed by the master clock. Each bit is 0 while channel 1's transmit clock is the reference.
- R7: When the master clock and channel 1's transmit clock are both static, all eight channel states are 11. Their level counters then hold their values.
- R8: `rx_state` is 00 (normal) while the master clock runs, 01 (slice only) while it is static high and 10 (powered down) while it is static low, whatever channel 1's transmit clock does.
- R9: The first synchronized edge of a transmit clock clears both of that channel's level counters, so the channel returns to state 00 while a reference runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_in | input | 1 | Master clock, sampled as data |
| tclk_in | input | 8 | Per-channel transmit clocks, sampled as data |
| chan_state | output | 16 | Two bits per channel: 00 normal, 01 TAOS, 10 power-down, 11 no-reference high-Z |
| taos_src_mclk | output | 8 | Per channel, 1 when the all-ones timing source is the master clock |
| rx_state | output | 2 | Receive path: 00 normal, 01 slice only, 10 powered down |

## Verification
The bench goes after the threshold edges. It checks a channel just before and just after 16 high ticks and 64 low ticks. An off-by-some counter would flip early or never. It stops the master clock so the same thresholds must be met in channel 1 ticks. A design that kept counting the dead master clock would never leave normal, and one that kept the source select at 1 would be caught as well. It then also freezes channel 1's clock and checks that every channel goes to high-Z while the receive path still follows only the master clock level. Finally it revives a stuck channel and checks that it clears back to normal, and that a frozen counter resumes correctly once a reference returns.

// File: rtl/txm_pkg.sv
package txm_pkg;
  typedef enum logic [1:0] {
    CM_NORMAL = 2'b00,
    CM_TAOS   = 2'b01,
    CM_PDN    = 2'b10,
    CM_HIZ    = 2'b11
  } chan_mode_e;

  typedef enum logic [1:0] {
    RX_NORMAL = 2'b00,
    RX_SLICE  = 2'b01,
    RX_PDN    = 2'b10
  } rx_mode_e;
endpackage

// File: rtl/clk_activity_mon.sv
module clk_activity_mon #(
  parameter int RUN_WIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic edge_seen,
  output logic lvl_prev,
  output logic running
);
  localparam int IW = $clog2(RUN_WIN + 1);

  logic s1, s2, s3;
  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sig_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_seen = s2 ^ s3;
  assign lvl_prev  = s3;

  always_ff @(posedge clk) begin
    if (!rst_n)
      idle_cnt <= IW'(RUN_WIN);
    else if (edge_seen)
      idle_cnt <= '0;
    else if (idle_cnt < IW'(RUN_WIN))
      idle_cnt <= idle_cnt + 1'b1;
  end

  assign running = (idle_cnt < IW'(RUN_WIN));

  // R2: an edge makes the clock count as running in the next cycle
  a_r2_edge_running: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> running);
endmodule

// File: rtl/ref_select.sv
module ref_select (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_run,
  input  logic mclk_edge,
  input  logic mclk_lvl,
  input  logic fb_run,
  input  logic fb_edge,
  input  logic fb_lvl,
  output logic ref_tick,
  output logic use_mclk,
  output logic no_ref
);
  // a rising edge is an edge whose previous level was low
  always_comb begin
    use_mclk = mclk_run;
    no_ref   = !mclk_run && !fb_run;
    if (mclk_run)
      ref_tick = mclk_edge && !mclk_lvl;
    else if (fb_run)
      ref_tick = fb_edge && !fb_lvl;
    else
      ref_tick = 1'b0;
  end

  // R7: without any running reference no tick is produced
  a_r7_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    no_ref |-> !ref_tick);
endmodule

// File: rtl/chan_level_ctrl.sv
module chan_level_ctrl
  import txm_pkg::*;
#(
  parameter int HI_TH = 16,
  parameter int LO_TH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tclk_edge,
  input  logic       tclk_lvl,
  input  logic       ref_tick,
  input  logic       no_ref,
  output chan_mode_e mode
);
  localparam int CW    = $clog2(LO_TH + 1);
  localparam int HI_SAT = HI_TH + 1;

  logic [CW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (tclk_edge) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (ref_tick && !no_ref) begin
      if (tclk_lvl) begin
        lo_cnt <= '0;
        if (hi_cnt < CW'(HI_SAT)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt < CW'(LO_TH)) lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (no_ref)
      mode = CM_HIZ;
    else if (hi_cnt >= CW'(HI_SAT))
      mode = CM_TAOS;
    else if (lo_cnt >= CW'(LO_TH))
      mode = CM_PDN;
    else
      mode = CM_NORMAL;
  end

  // R3: all-ones only while the clock sits high
  a_r3_taos_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_TAOS) |-> tclk_lvl);
  // R4: power-down only while the clock sits low
  a_r4_pdn_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_PDN) |-> !tclk_lvl);
  // R9: an edge clears both level counters
  a_r9_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tclk_edge |=> (hi_cnt == '0 && lo_cnt == '0));
  // R4: the low counter never passes its limit
  a_r4_lo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= CW'(LO_TH));
endmodule

// File: rtl/txclk_mode_ctrl.sv
module txclk_mode_ctrl
  import txm_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int REF_CH  = 1,
  parameter int RUN_WIN = 8,
  parameter int HI_TH   = 16,
  parameter int LO_TH   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclk_in,
  input  logic [NCH-1:0]   tclk_in,
  output logic [2*NCH-1:0] chan_state,
  output logic [NCH-1:0]   taos_src_mclk,
  output logic [1:0]       rx_state
);
  logic mclk_edge, mclk_lvl, mclk_run;
  logic [NCH-1:0] t_edge, t_lvl, t_run;
  logic ref_tick, use_mclk, no_ref;
  chan_mode_e ch_mode [NCH];

  clk_activity_mon #(.RUN_WIN(RUN_WIN)) u_mclk_mon (
    .clk(clk), .rst_n(rst_n), .sig_in(mclk_in),
    .edge_seen(mclk_edge), .lvl_prev(mclk_lvl), .running(mclk_run));

  ref_select u_ref (
    .clk(clk), .rst_n(rst_n),
    .mclk_run(mclk_run), .mclk_edge(mclk_edge), .mclk_lvl(mclk_lvl),
    .fb_run(t_run[REF_CH]), .fb_edge(t_edge[REF_CH]), .fb_lvl(t_lvl[REF_CH]),
    .ref_tick(ref_tick), .use_mclk(use_mclk), .no_ref(no_ref));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    clk_activity_mon #(.RUN_WIN(RUN_WIN)) u_mon (
      .clk(clk), .rst_n(rst_n), .sig_in(tclk_in[i]),
      .edge_seen(t_edge[i]), .lvl_prev(t_lvl[i]), .running(t_run[i]));

    chan_level_ctrl #(.HI_TH(HI_TH), .LO_TH(LO_TH)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .tclk_edge(t_edge[i]), .tclk_lvl(t_lvl[i]),
      .ref_tick(ref_tick), .no_ref(no_ref), .mode(ch_mode[i]));

    assign chan_state[2*i +: 2] = ch_mode[i];
    assign taos_src_mclk[i]     = use_mclk;
  end

  always_comb begin
    if (mclk_run)      rx_state = RX_NORMAL;
    else if (mclk_lvl) rx_state = RX_SLICE;
    else               rx_state = RX_PDN;
  end

  // R7: no reference at all forces every channel to high-Z
  a_r7_hiz_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclk_run && !t_run[REF_CH]) |-> (chan_state == {NCH{2'b11}}));
  // R8: receive path normal exactly while the master clock runs
  a_r8_rx_run: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_edge |=> (rx_state == 2'b00));
endmodule

// File: tb/sim_txclk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_txclk_mode_ctrl;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk_in = 1'b0;
  logic [NCH-1:0] tclk_in = '0;
  logic [2*NCH-1:0] chan_state;
  logic [NCH-1:0] taos_src_mclk;
  logic [1:0] rx_state;

  always #2.5 clk = ~clk;  // 200 MHz

  txclk_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .tclk_in(tclk_in),
    .chan_state(chan_state), .taos_src_mclk(taos_src_mclk), .rx_state(rx_state));

  // clock modes: 0 toggle, 1 static high, 2 static low
  int m_mode = 2;
  int t_mode [NCH];
  int ph = 0;

  always @(negedge clk) begin
    ph <= ph + 1;
    if (ph % 4 == 0) begin
      if (m_mode == 0) mclk_in <= ~mclk_in;
      for (int i = 0; i < NCH; i++)
        if (t_mode[i] == 0) tclk_in[i] <= ~tclk_in[i];
    end
    if (m_mode == 1) mclk_in <= 1'b1;
    if (m_mode == 2) mclk_in <= 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (t_mode[i] == 1) tclk_in[i] <= 1'b1;
      if (t_mode[i] == 2) tclk_in[i] <= 1'b0;
    end
  end

  typedef struct {
    string tag;
    logic [2*NCH-1:0] cs;
    logic [NCH-1:0] src;
    logic [1:0] rx;
  } exp_t;

  exp_t q [$];
  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0] exp_ch [NCH];

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2*NCH-1:0] pack_exp();
    logic [2*NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[2*i +: 2] = exp_ch[i];
    return v;
  endfunction

  // driver side: push an expectation, monitor compares at the next negedge
  task automatic expect_now(input string tag, input logic [NCH-1:0] src,
                            input logic [1:0] rx);
    exp_t e;
    e.tag = tag; e.cs = pack_exp(); e.src = src; e.rx = rx;
    q.push_back(e);
    wait_cyc(2);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (chan_state !== e.cs || taos_src_mclk !== e.src || rx_state !== e.rx) begin
        n_bad++;
        $display("FAIL %s: state=%h src=%h rx=%b expected state=%h src=%h rx=%b",
                 e.tag, chan_state, taos_src_mclk, rx_state, e.cs, e.src, e.rx);
      end
    end
  end

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin t_mode[i] = 2; exp_ch[i] = 2'b11; end
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(1);
    expect_now("R1 reset state", 8'h00, 2'b10);

    // all clocks toggling
    m_mode = 0;
    for (int i = 0; i < NCH; i++) begin t_mode[i] = 0; exp_ch[i] = 2'b00; end
    wait_cyc(40);
    expect_now("R2 all running normal", 8'hFF, 2'b00);
    expect_now("R6 master clock source", 8'hFF, 2'b00);

    // ch3 stuck high, 8 cycles per master tick
    t_mode[3] = 1;
    wait_cyc(14 * 8);
    expect_now("R3 ch3 high below threshold", 8'hFF, 2'b00);
    wait_cyc(8 * 8);
    exp_ch[3] = 2'b01;
    expect_now("R3 ch3 TAOS", 8'hFF, 2'b00);

    // ch5 stuck low
    t_mode[5] = 2;
    wait_cyc(60 * 8);
    expect_now("R4 ch5 low below threshold", 8'hFF, 2'b00);
    wait_cyc(10 * 8);
    exp_ch[5] = 2'b10;
    expect_now("R4 ch5 power-down", 8'hFF, 2'b00);

    // revive both
    t_mode[3] = 0; t_mode[5] = 0;
    wait_cyc(12);
    exp_ch[3] = 2'b00; exp_ch[5] = 2'b00;
    expect_now("R9 channels back to normal", 8'hFF, 2'b00);

    // master static high: fallback to channel 1
    m_mode = 1;
    wait_cyc(20);
    expect_now("R8 rx slice, R6 fallback source", 8'h00, 2'b01);
    t_mode[2] = 1;
    wait_cyc(14 * 8);
    expect_now("R5 ch2 high below fallback threshold", 8'h00, 2'b01);
    wait_cyc(8 * 8);
    exp_ch[2] = 2'b01;
    expect_now("R5 ch2 TAOS on fallback ticks", 8'h00, 2'b01);
    t_mode[4] = 2;
    wait_cyc(60 * 8);
    expect_now("R5 ch4 low below fallback threshold", 8'h00, 2'b01);
    wait_cyc(10 * 8);
    exp_ch[4] = 2'b10;
    expect_now("R5 ch4 power-down on fallback ticks", 8'h00, 2'b01);

    // channel 1 also stops: no reference
    t_mode[1] = 2;
    wait_cyc(20);
    for (int i = 0; i < NCH; i++) exp_ch[i] = 2'b11;
    expect_now("R7 all high-Z, R8 rx still slice", 8'h00, 2'b01);
    m_mode = 2;
    wait_cyc(20);
    expect_now("R8 rx powered down, R7 still high-Z", 8'h00, 2'b10);

    // master returns: ch2 keeps its frozen TAOS count, ch4 its low count
    m_mode = 0;
    wait_cyc(20);
    for (int i = 0; i < NCH; i++) exp_ch[i] = 2'b00;
    exp_ch[2] = 2'b01; exp_ch[4] = 2'b10;
    expect_now("R7 counters held, R2 normal restored", 8'hFF, 2'b00);
    t_mode[2] = 0;
    wait_cyc(12);
    exp_ch[2] = 2'b00;
    expect_now("R9 ch2 revived", 8'hFF, 2'b00);

    wait_cyc(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule